// File: doc/BRIEF.md
# Bypassable Hold Buffer with Thread-Selective Squash

This block sits between two stages of an in-order pipeline. Every instruction offered to it arrives as a tag made of a thread number and a sequence number. In the same cycle the block decides whether the tag may skip the buffered stage and go straight to the stage two positions ahead, or whether it must be held. Held tags are kept oldest-first in a small compacting store.

Held tags leave in one of three ways. The consumer can pop the oldest. A tag can be deleted by identity from any position when its instruction reaches the stage two positions ahead. A squash deletes every tag of one thread that is younger than a given sequence number. Survivors always close up and keep their relative order. Two status inputs from the downstream stage drive the skip decision: a per-thread blocked vector and a one-bit "input slot free" flag.

All removals in a cycle are applied before the offered tag is judged. The order is squash, then delete-by-tag, then pop. The skip and full decisions for the new tag therefore use the occupancy that is left after them.

Top module: `bypass_hold_buffer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the store is emptied (`occupancy` = 0, `head_valid` = 0) and `bypass_total` is cleared to 0.
- R2: An offered tag skips the buffer (`skip_go` = 1 in that cycle, `hold_go` = 0) only if three conditions all hold: the store is empty after that cycle's removals, `dn_blocked[in_tid]` is 0, and `dn_has_room` is 1. A skipped tag is never stored, and `bypass_total` rises by one at the next edge.
- R3: An offered tag that may not skip, while fewer than DEPTH entries remain after removals, is held (`hold_go` = 1) and appended behind all older entries. `bypass_total` does not change.
- R4: An offered tag that may not skip, while DEPTH entries remain after removals, is refused (`hold_refused` = 1) and the store contents are unchanged.
- R5: A delete request (`rm_valid`) deletes only the oldest entry whose thread and sequence number both equal `rm_tid`/`rm_seq`. All other entries keep their order.
- R6: A delete request that matches no surviving entry leaves the store unchanged. It makes `rm_miss` high for exactly the one following cycle.
- R7: `head_valid`, `head_tid` and `head_seq` show the oldest entry. `pop_req` discards it. A pop on an empty store has no effect.
- R8: A squash (`sq_valid`) deletes every entry whose thread equals `sq_tid` and whose sequence number is unsigned-greater than `sq_seq`. In that same cycle, `sq_kill` bit i is 1 exactly when store slot i (slot 0 = oldest) is being deleted.
- R9: Entries of other threads, and entries of the squashing thread whose sequence number is less than or equal to `sq_seq`, survive a squash in their original order.
- R10: A squash in the same cycle as an offered tag is applied first. A store that was full can therefore accept the tag, and a store emptied by the squash lets the tag skip.
- R11: The blocked input is per thread: `dn_blocked` bits of other threads do not stop a tag from skipping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A tag is offered this cycle |
| in_tid | input | TID_W | Thread of the offered tag |
| in_seq | input | SEQ_W | Sequence number of the offered tag |
| dn_blocked | input | 2**TID_W | Downstream target stage blocked, one bit per thread |
| dn_has_room | input | 1 | Downstream target stage has a free input slot |
| skip_go | output | 1 | Offered tag goes to the stage two ahead |
| hold_go | output | 1 | Offered tag is appended to the store |
| hold_refused | output | 1 | Offered tag refused, store full |
| rm_valid | input | 1 | Delete-by-tag request |
| rm_tid | input | TID_W | Thread of the tag to delete |
| rm_seq | input | SEQ_W | Sequence number of the tag to delete |
| rm_miss | output | 1 | Previous cycle's delete request found nothing |
| head_valid | output | 1 | Store holds at least one entry |
| head_tid | output | TID_W | Thread of the oldest entry |
| head_seq | output | SEQ_W | Sequence number of the oldest entry |
| pop_req | input | 1 | Discard the oldest entry |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread being squashed |
| sq_seq | input | SEQ_W | Entries younger than this are deleted |
| sq_kill | output | DEPTH | Per-slot squashed indication for this cycle |
| occupancy | output | $clog2(DEPTH+1) | Number of stored entries |
| bypass_total | output | BCNT_W | Count of tags that skipped |

## Verification
The bench stores the same tag twice and deletes it once. A design that deletes the last match instead of the first would present a different head. It squashes with one entry exactly equal to the squash number and one entry of another thread between the victims. An off-by-one compare, or a squash that ignores the thread, would then lose a survivor or reorder what remains. It offers a tag to a full store in the same cycle as a squash, and to a one-entry store while that entry is squashed. A design that judged occupancy before the squash would refuse the first tag and hold the second instead of letting it skip. It also blocks a thread other than the offered one, and issues deletes that miss on only the thread or only the sequence number. Misread status or a loose match shows up as a wrong decision or a missing `rm_miss` pulse.

// File: rtl/hbuf_pkg.sv
// Package: shared decision type for the bypassable hold buffer.
// Assumes: nothing; pure type definitions.
package hbuf_pkg;

    // Outcome of an offered tag in the current cycle.
    typedef enum logic [1:0] {
        DEC_NONE   = 2'd0,
        DEC_SKIP   = 2'd1,
        DEC_HOLD   = 2'd2,
        DEC_REFUSE = 2'd3
    } hbuf_dec_e;

endpackage

// File: rtl/hbuf_select.sv
// Module: hbuf_select
// Works out, for each stored slot, whether it dies this cycle: first by
// squash, then by delete-by-tag (oldest surviving match only), then by pop
// (oldest surviving entry). Produces the keep mask for compaction.
// Assumes: entries occupy slots 0..cnt-1 contiguously, slot 0 is oldest.
module hbuf_select #(
    parameter int DEPTH = 4,
    parameter int TID_W = 2,
    parameter int SEQ_W = 16,
    localparam int ENT_W = TID_W + SEQ_W,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ENT_W-1:0] ents [DEPTH],
    input  logic [CNT_W-1:0] cnt,
    input  logic             sq_valid,
    input  logic [TID_W-1:0] sq_tid,
    input  logic [SEQ_W-1:0] sq_seq,
    input  logic             rm_valid,
    input  logic [TID_W-1:0] rm_tid,
    input  logic [SEQ_W-1:0] rm_seq,
    input  logic             pop_req,
    output logic [DEPTH-1:0] kill,
    output logic             rm_none,
    output logic [DEPTH-1:0] keep
);

    logic [DEPTH-1:0] occ;
    logic [DEPTH-1:0] rm_cand;
    logic [DEPTH-1:0] rm_hit;
    logic [DEPTH-1:0] alive;
    logic [DEPTH-1:0] pop_hit;

    // Per-slot occupancy, squash victim and delete candidate.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [TID_W-1:0] e_tid;
        logic [SEQ_W-1:0] e_seq;
        assign e_tid      = ents[g][ENT_W-1:SEQ_W];
        assign e_seq      = ents[g][SEQ_W-1:0];
        assign occ[g]     = (CNT_W'(g) < cnt);
        assign kill[g]    = occ[g] && sq_valid && (e_tid == sq_tid) && (e_seq > sq_seq);
        assign rm_cand[g] = occ[g] && !kill[g] && rm_valid &&
                            (e_tid == rm_tid) && (e_seq == rm_seq);
    end

    // Oldest matching candidate wins the delete.
    always_comb begin
        logic found;
        found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            rm_hit[i] = rm_cand[i] && !found;
            found     = found || rm_cand[i];
        end
        rm_none = rm_valid && !found;
    end

    assign alive = occ & ~kill & ~rm_hit;

    // Pop takes the oldest entry still alive after squash and delete.
    always_comb begin
        logic found;
        found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            pop_hit[i] = pop_req && alive[i] && !found;
            found      = found || alive[i];
        end
    end

    assign keep = alive & ~pop_hit;

    AST_RM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rm_hit)); // R5

    AST_RM_NOT_SQUASHED: assert property (@(posedge clk) disable iff (!rst_n)
        (rm_hit & kill) == '0); // R10

endmodule

// File: rtl/hbuf_compact.sv
// Module: hbuf_compact
// Closes the gaps left by deleted entries, keeping age order, and appends
// an accepted tag behind the survivors.
// Assumes: ins_en is only raised when fewer than DEPTH entries survive.
module hbuf_compact #(
    parameter int DEPTH = 4,
    parameter int ENT_W = 18,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [ENT_W-1:0] ents     [DEPTH],
    input  logic [DEPTH-1:0] keep,
    input  logic             ins_en,
    input  logic [ENT_W-1:0] ins_ent,
    output logic [CNT_W-1:0] kept_cnt,
    output logic [ENT_W-1:0] nxt_ents [DEPTH],
    output logic [CNT_W-1:0] nxt_cnt
);

    // Number of entries that survive this cycle.
    always_comb begin
        kept_cnt = CNT_W'($countones(keep));
    end

    // Pack survivors toward slot 0, then place the new tag at the tail.
    always_comb begin
        int k;
        k = 0;
        for (int j = 0; j < DEPTH; j++) begin
            nxt_ents[j] = '0;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (keep[i]) begin
                nxt_ents[k] = ents[i];
                k = k + 1;
            end
        end
        if (ins_en && (k < DEPTH)) begin
            nxt_ents[k] = ins_ent;
        end
        nxt_cnt = kept_cnt + CNT_W'(ins_en);
    end

endmodule

// File: rtl/hbuf_decide.sv
// Module: hbuf_decide
// Judges an offered tag (skip, hold or refuse) against the post-removal
// occupancy and downstream status, and counts skipped tags.
// Assumes: kept_cnt already reflects this cycle's squash, delete and pop.
module hbuf_decide #(
    parameter int DEPTH  = 4,
    parameter int TID_W  = 2,
    parameter int BCNT_W = 16,
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int THREADS = 1 << TID_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [TID_W-1:0]    in_tid,
    input  logic [THREADS-1:0]  dn_blocked,
    input  logic                dn_has_room,
    input  logic [CNT_W-1:0]    kept_cnt,
    output hbuf_pkg::hbuf_dec_e dec,
    output logic [BCNT_W-1:0]   skip_cnt
);
    import hbuf_pkg::*;

    logic can_skip;
    logic has_space;

    // Decision for the offered tag.
    always_comb begin
        can_skip  = (kept_cnt == '0) && !dn_blocked[in_tid] && dn_has_room;
        has_space = (kept_cnt < CNT_W'(DEPTH));
        if (!in_valid)      dec = DEC_NONE;
        else if (can_skip)  dec = DEC_SKIP;
        else if (has_space) dec = DEC_HOLD;
        else                dec = DEC_REFUSE;
    end

    // Running count of skipped tags.
    always_ff @(posedge clk) begin
        if (!rst_n)              skip_cnt <= '0;
        else if (dec == DEC_SKIP) skip_cnt <= skip_cnt + 1'b1;
    end

    AST_SKIP_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        (dec == DEC_SKIP) |=> (skip_cnt == $past(skip_cnt) + 1'b1)); // R2

    AST_NO_SKIP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dn_blocked[in_tid]) |-> (dec != DEC_SKIP)); // R11

endmodule

// File: rtl/bypass_hold_buffer.sv
// Module: bypass_hold_buffer (top)
// Pipeline hold buffer that lets a tag skip one stage when the store is
// empty and the downstream stage accepts, otherwise stores it oldest-first.
// Supports pop, delete-by-tag and thread-selective squash of younger tags.
// Assumes: sequence numbers compare as plain unsigned values (no wrap).
module bypass_hold_buffer #(
    parameter int DEPTH  = 4,
    parameter int TID_W  = 2,
    parameter int SEQ_W  = 16,
    parameter int BCNT_W = 16,
    localparam int ENT_W   = TID_W + SEQ_W,
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int THREADS = 1 << TID_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [TID_W-1:0]   in_tid,
    input  logic [SEQ_W-1:0]   in_seq,
    input  logic [THREADS-1:0] dn_blocked,
    input  logic               dn_has_room,
    output logic               skip_go,
    output logic               hold_go,
    output logic               hold_refused,
    input  logic               rm_valid,
    input  logic [TID_W-1:0]   rm_tid,
    input  logic [SEQ_W-1:0]   rm_seq,
    output logic               rm_miss,
    output logic               head_valid,
    output logic [TID_W-1:0]   head_tid,
    output logic [SEQ_W-1:0]   head_seq,
    input  logic               pop_req,
    input  logic               sq_valid,
    input  logic [TID_W-1:0]   sq_tid,
    input  logic [SEQ_W-1:0]   sq_seq,
    output logic [DEPTH-1:0]   sq_kill,
    output logic [CNT_W-1:0]   occupancy,
    output logic [BCNT_W-1:0]  bypass_total
);
    import hbuf_pkg::*;

    logic [ENT_W-1:0] ents_q   [DEPTH];
    logic [ENT_W-1:0] nxt_ents [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nxt_cnt;
    logic [CNT_W-1:0] kept_cnt;
    logic [DEPTH-1:0] keep;
    logic             rm_none;
    logic             rm_miss_q;
    hbuf_dec_e        dec;

    hbuf_select #(.DEPTH(DEPTH), .TID_W(TID_W), .SEQ_W(SEQ_W)) u_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .ents     (ents_q),
        .cnt      (cnt_q),
        .sq_valid (sq_valid),
        .sq_tid   (sq_tid),
        .sq_seq   (sq_seq),
        .rm_valid (rm_valid),
        .rm_tid   (rm_tid),
        .rm_seq   (rm_seq),
        .pop_req  (pop_req),
        .kill     (sq_kill),
        .rm_none  (rm_none),
        .keep     (keep)
    );

    hbuf_decide #(.DEPTH(DEPTH), .TID_W(TID_W), .BCNT_W(BCNT_W)) u_decide (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_tid      (in_tid),
        .dn_blocked  (dn_blocked),
        .dn_has_room (dn_has_room),
        .kept_cnt    (kept_cnt),
        .dec         (dec),
        .skip_cnt    (bypass_total)
    );

    hbuf_compact #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_compact (
        .ents     (ents_q),
        .keep     (keep),
        .ins_en   (dec == DEC_HOLD),
        .ins_ent  ({in_tid, in_seq}),
        .kept_cnt (kept_cnt),
        .nxt_ents (nxt_ents),
        .nxt_cnt  (nxt_cnt)
    );

    // Store update: empty on reset, otherwise take the compacted image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) ents_q[i] <= '0;
        end else begin
            cnt_q  <= nxt_cnt;
            ents_q <= nxt_ents;
        end
    end

    // One-cycle flag for a delete request that found nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) rm_miss_q <= 1'b0;
        else        rm_miss_q <= rm_none;
    end

    assign skip_go      = (dec == DEC_SKIP);
    assign hold_go      = (dec == DEC_HOLD);
    assign hold_refused = (dec == DEC_REFUSE);
    assign rm_miss      = rm_miss_q;
    assign head_valid   = (cnt_q != '0);
    assign head_tid     = ents_q[0][ENT_W-1:SEQ_W];
    assign head_seq     = ents_q[0][SEQ_W-1:0];
    assign occupancy    = cnt_q;

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(DEPTH)); // R4

    AST_HOLD_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_go && !sq_valid && !rm_valid && !pop_req)
        |=> (occupancy == $past(occupancy) + 1'b1)); // R3

    AST_REFUSE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_refused && !sq_valid && !rm_valid && !pop_req)
        |=> (occupancy == $past(occupancy))); // R4

    AST_MISS_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rm_miss |-> $past(rm_valid)); // R6

    AST_POP_EMPTY_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && occupancy == '0 && !in_valid) |=> (occupancy == '0)); // R7

    AST_SKIP_LEAVES_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        skip_go |=> !head_valid); // R2

endmodule

// File: tb/bypass_hold_buffer_bench.sv
`timescale 1ns/1ps
module bypass_hold_buffer_bench;

    localparam int DEPTH = 4;
    localparam int TID_W = 2;
    localparam int SEQ_W = 16;
    localparam int BCNT_W = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid;
    logic [TID_W-1:0] in_tid;
    logic [SEQ_W-1:0] in_seq;
    logic [3:0] dn_blocked;
    logic dn_has_room;
    logic skip_go, hold_go, hold_refused;
    logic rm_valid;
    logic [TID_W-1:0] rm_tid;
    logic [SEQ_W-1:0] rm_seq;
    logic rm_miss;
    logic head_valid;
    logic [TID_W-1:0] head_tid;
    logic [SEQ_W-1:0] head_seq;
    logic pop_req;
    logic sq_valid;
    logic [TID_W-1:0] sq_tid;
    logic [SEQ_W-1:0] sq_seq;
    logic [DEPTH-1:0] sq_kill;
    logic [CNT_W-1:0] occupancy;
    logic [BCNT_W-1:0] bypass_total;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_tid [4];
    int exp_seq [4];

    always #10 clk = ~clk;

    bypass_hold_buffer #(.DEPTH(DEPTH), .TID_W(TID_W), .SEQ_W(SEQ_W), .BCNT_W(BCNT_W))
    u_bypass_hold_buffer (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_tid(in_tid), .in_seq(in_seq),
        .dn_blocked(dn_blocked), .dn_has_room(dn_has_room),
        .skip_go(skip_go), .hold_go(hold_go), .hold_refused(hold_refused),
        .rm_valid(rm_valid), .rm_tid(rm_tid), .rm_seq(rm_seq), .rm_miss(rm_miss),
        .head_valid(head_valid), .head_tid(head_tid), .head_seq(head_seq),
        .pop_req(pop_req),
        .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq), .sq_kill(sq_kill),
        .occupancy(occupancy), .bypass_total(bypass_total)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        in_valid = 0; in_tid = 0; in_seq = 0;
        rm_valid = 0; rm_tid = 0; rm_seq = 0;
        pop_req = 0; sq_valid = 0; sq_tid = 0; sq_seq = 0;
    endtask

    // Offer a tag and check that it is held.
    task automatic push_hold(input int t, input int s, input string req);
        in_valid = 1; in_tid = TID_W'(t); in_seq = SEQ_W'(s);
        #1;
        chk({req, " hold_go"}, int'(hold_go), 1);
        step();
        in_valid = 0;
    endtask

    // Pop n entries, checking the head order against exp_tid/exp_seq.
    task automatic drain(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            chk({req, " head_valid"}, int'(head_valid), 1);
            chk({req, " head_tid"}, int'(head_tid), exp_tid[i]);
            chk({req, " head_seq"}, int'(head_seq), exp_seq[i]);
            pop_req = 1;
            step();
            pop_req = 0;
        end
        chk({req, " empty after drain"}, int'(occupancy), 0);
    endtask

    task automatic t_reset();
        chk("R1 occupancy", int'(occupancy), 0);
        chk("R1 head_valid", int'(head_valid), 0);
        chk("R1 bypass_total", int'(bypass_total), 0);
    endtask

    task automatic t_skip();
        dn_blocked = 4'b0000; dn_has_room = 1;
        in_valid = 1; in_tid = 1; in_seq = 10;
        #1;
        chk("R2 skip_go", int'(skip_go), 1);
        chk("R2 hold_go", int'(hold_go), 0);
        step(); in_valid = 0;
        chk("R2 not stored", int'(occupancy), 0);
        chk("R2 count", int'(bypass_total), 1);
        // R11: another thread's blocked bit does not stop thread 1.
        dn_blocked = 4'b1101;
        in_valid = 1; in_tid = 1; in_seq = 11;
        #1;
        chk("R11 skip_go", int'(skip_go), 1);
        step(); in_valid = 0;
        chk("R11 count", int'(bypass_total), 2);
        dn_blocked = 4'b0000;
    endtask

    task automatic t_hold();
        dn_blocked = 4'b0100; dn_has_room = 1;
        push_hold(2, 20, "R3 blocked thread");
        dn_blocked = 4'b0000; dn_has_room = 0;
        push_hold(1, 5, "R3 no room");
        dn_has_room = 1;
        push_hold(0, 7, "R3 not empty");
        chk("R3 occupancy", int'(occupancy), 3);
        chk("R3 count unchanged", int'(bypass_total), 2);
        exp_tid = '{2, 1, 0, 0}; exp_seq = '{20, 5, 7, 0};
        drain(3, "R3 order");
    endtask

    task automatic t_full();
        dn_has_room = 0;
        push_hold(0, 1, "R4 fill");
        push_hold(1, 2, "R4 fill");
        push_hold(2, 3, "R4 fill");
        push_hold(3, 4, "R4 fill");
        in_valid = 1; in_tid = 0; in_seq = 9;
        #1;
        chk("R4 hold_refused", int'(hold_refused), 1);
        chk("R4 hold_go", int'(hold_go), 0);
        step(); in_valid = 0;
        chk("R4 occupancy", int'(occupancy), 4);
        exp_tid = '{0, 1, 2, 3}; exp_seq = '{1, 2, 3, 4};
        drain(4, "R4 contents");
    endtask

    task automatic t_remove();
        dn_has_room = 0;
        push_hold(1, 30, "R5 fill");
        push_hold(2, 31, "R5 fill");
        push_hold(1, 30, "R5 fill");
        push_hold(3, 32, "R5 fill");
        rm_valid = 1; rm_tid = 1; rm_seq = 30;
        step(); rm_valid = 0;
        chk("R5 occupancy", int'(occupancy), 3);
        chk("R5 no miss", int'(rm_miss), 0);
        exp_tid = '{2, 1, 3, 0}; exp_seq = '{31, 30, 32, 0};
        drain(3, "R5 order");
    endtask

    task automatic t_miss();
        dn_has_room = 0;
        push_hold(0, 40, "R6 fill");
        rm_valid = 1; rm_tid = 0; rm_seq = 41;
        step(); rm_valid = 0;
        chk("R6 miss seq", int'(rm_miss), 1);
        chk("R6 occupancy", int'(occupancy), 1);
        step();
        chk("R6 one cycle", int'(rm_miss), 0);
        rm_valid = 1; rm_tid = 1; rm_seq = 40;
        step(); rm_valid = 0;
        chk("R6 miss tid", int'(rm_miss), 1);
        chk("R6 occupancy tid", int'(occupancy), 1);
        exp_tid = '{0, 0, 0, 0}; exp_seq = '{40, 0, 0, 0};
        drain(1, "R6 contents");
    endtask

    task automatic t_pop_empty();
        pop_req = 1;
        step(); pop_req = 0;
        chk("R7 pop empty occupancy", int'(occupancy), 0);
        chk("R7 pop empty head_valid", int'(head_valid), 0);
    endtask

    task automatic t_squash();
        dn_has_room = 0;
        push_hold(1, 10, "R8 fill");
        push_hold(2, 50, "R8 fill");
        push_hold(1, 12, "R8 fill");
        push_hold(1, 11, "R8 fill");
        sq_valid = 1; sq_tid = 1; sq_seq = 10;
        #1;
        chk("R8 sq_kill", int'(sq_kill), 4'b1100);
        step(); sq_valid = 0;
        chk("R8 occupancy", int'(occupancy), 2);
        exp_tid = '{1, 2, 0, 0}; exp_seq = '{10, 50, 0, 0};
        drain(2, "R9 survivors");
    endtask

    task automatic t_squash_insert();
        dn_has_room = 0;
        push_hold(0, 1, "R10 fill");
        push_hold(0, 2, "R10 fill");
        push_hold(3, 3, "R10 fill");
        push_hold(0, 4, "R10 fill");
        sq_valid = 1; sq_tid = 0; sq_seq = 1;
        in_valid = 1; in_tid = 2; in_seq = 60;
        #1;
        chk("R10 accepted after squash", int'(hold_go), 1);
        chk("R10 not refused", int'(hold_refused), 0);
        step(); sq_valid = 0; in_valid = 0;
        chk("R10 occupancy", int'(occupancy), 3);
        exp_tid = '{0, 3, 2, 0}; exp_seq = '{1, 3, 60, 0};
        drain(3, "R10 order");
        push_hold(1, 70, "R10 fill one");
        dn_has_room = 1;
        sq_valid = 1; sq_tid = 1; sq_seq = 0;
        in_valid = 1; in_tid = 0; in_seq = 71;
        #1;
        chk("R10 skip after squash", int'(skip_go), 1);
        chk("R8 kill single", int'(sq_kill), 4'b0001);
        step(); sq_valid = 0; in_valid = 0;
        chk("R10 empty", int'(occupancy), 0);
        chk("R10 count", int'(bypass_total), 3);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0;
        idle();
        dn_blocked = 0; dn_has_room = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_skip();
        t_hold();
        t_full();
        t_remove();
        t_miss();
        t_pop_empty();
        t_squash();
        t_squash_insert();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule